// File: doc/BRIEF.md
# Pseudo-SRAM Auto-Refresh Controller

This block keeps a pseudo-SRAM alive by running auto-refresh cycles on its chip-enable and output-enable pins at a programmable rate. A free-running prescaler divides the system clock. A 3-bit select field picks one of its taps as the timer step. An 8-bit up-counter advances on each step and is compared against a constant register. When the two are equal, the counter returns to zero and a refresh request is raised.

A raised request waits until the external access-busy input is low. The block then drives one refresh cycle. CE falls first. OE follows one cycle later and stays low for a programmed number of cycles. Both pins then rise together, and CE stays high for a programmed precharge time before another refresh can begin. A request that arrives while one is still waiting sets a sticky overflow flag, so a lost refresh can be seen. Software programs the block through four byte-wide registers on a simple write/read port.

Top module: `psram_refresh_ctl`

## Requirements
- R1: After reset, all four registers read 0 and both ce_n and oe_n are high.
- R2: Refresh cycles are generated only while the control register has its enable bit (bit 0) at 1 and its mode bit (bit 1) at 0; with any other combination, ce_n stays high.
- R3: While the timer select field (address 1, bits [2:0]) is 000, the count register holds its value.
- R4: When a nonzero select code is written, counting continues upward from the value the count register already holds; the count is not cleared.
- R5: Select codes 1 to 7 step the counter once every 4, 16, 64, 256, 1024, 2048 and 4096 system clocks respectively.
- R6: At a timer step where the count equals the constant register, the count returns to 0 and a refresh is requested, so refreshes start every (constant+1)×divider clocks.
- R7: During a refresh cycle, oe_n is low for (F+2) clocks, where F is control bits [3:2].
- R8: Each refresh cycle drops ce_n one clock before oe_n; ce_n and oe_n rise on the same edge; oe_n is never low while ce_n is high.
- R9: When another request is already waiting at the end of a cycle, ce_n stays high for exactly (P+1) clocks after oe_n rises before it falls again, where P is control bits [5:4].
- R10: No refresh cycle starts while busy is high; a waiting request starts (ce_n falls) on the first clock edge at which busy is low.
- R11: A request raised while another is still waiting sets control bit 7; the bit stays set until control is written with bit 7 = 1.
- R12: Registers sit at address 0 (control), 1 (timer select), 2 (count) and 3 (constant), and read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | External access in progress; holds off refresh start |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | CW (8) | Register write data |
| rdata | output | CW (8) | Register read data for addr |
| ce_n | output | 1 | Memory chip enable, active low, registered |
| oe_n | output | 1 | Memory output enable / refresh strobe, active low, registered |

## Verification
The checker watches every cycle for pin ordering: OE is never low outside CE, CE always falls while OE is high, and a cycle never starts on an edge where busy was high. It also checks that the count freezes when no timer clock is selected and that the overflow flag is sticky. Refresh interval, OE pulse length, precharge gap, divider ratios and resumption of counting from a held value depend on programmed values across many cycles. The bench scenarios measure these at the pins and through register reads.

// File: rtl/psram_refresh_ctl.sv
module psram_refresh_ctl #(
  parameter int CW    = 8,
  parameter int PRE_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          ce_n,
  output logic          oe_n
);

  typedef enum logic [1:0] {S_IDLE, S_TRC, S_TRR, S_TPC} st_t;

  logic          en_q, mode_q, ovf_q, pend_q;
  logic [1:0]    tras_q, tpc_q;
  logic [2:0]    cks_q;
  logic [CW-1:0] cnt_q, cor_q;
  logic [PRE_W-1:0] pre_q;
  st_t           st_q, st_d;
  logic [2:0]    ph_q, ph_d;
  logic          tick, hit, ev, go, start;

  wire wr_ctl  = wr_en && addr == 2'd0;
  wire wr_cks  = wr_en && addr == 2'd1;
  wire wr_cnt  = wr_en && addr == 2'd2;
  wire wr_cor  = wr_en && addr == 2'd3;
  wire clr_ovf = wr_ctl && wdata[7];

  always_comb begin
    case (cks_q)
      3'd1:    tick = &pre_q[1:0];
      3'd2:    tick = &pre_q[3:0];
      3'd3:    tick = &pre_q[5:0];
      3'd4:    tick = &pre_q[7:0];
      3'd5:    tick = &pre_q[9:0];
      3'd6:    tick = &pre_q[10:0];
      3'd7:    tick = &pre_q[11:0];
      default: tick = 1'b0;
    endcase
  end

  assign hit   = tick && (cnt_q == cor_q);
  assign ev    = hit && en_q && !mode_q;
  assign go    = pend_q && !busy;
  assign start = go && (st_q == S_IDLE || (st_q == S_TPC && ph_q == 3'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (wr_cnt)    cnt_q <= wdata;
      else if (tick) cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mode_q <= 1'b0; tras_q <= '0; tpc_q <= '0;
      cks_q <= '0; cor_q <= '0;
    end else begin
      if (wr_ctl) begin
        en_q   <= wdata[0];
        mode_q <= wdata[1];
        tras_q <= wdata[3:2];
        tpc_q  <= wdata[5:4];
      end
      if (wr_cks) cks_q <= wdata[2:0];
      if (wr_cor) cor_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q && !start) || ev;
      if (ev && pend_q && !start) ovf_q <= 1'b1;
      else if (clr_ovf)           ovf_q <= 1'b0;
    end
  end

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    case (st_q)
      S_IDLE: if (go) st_d = S_TRC;
      S_TRC: begin
        st_d = S_TRR;
        ph_d = {1'b0, tras_q} + 3'd1;
      end
      S_TRR:
        if (ph_q == 3'd0) begin
          st_d = S_TPC;
          ph_d = {1'b0, tpc_q};
        end else ph_d = ph_q - 3'd1;
      S_TPC:
        if (ph_q == 3'd0) st_d = go ? S_TRC : S_IDLE;
        else              ph_d = ph_q - 3'd1;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      ph_q <= '0;
      ce_n <= 1'b1;
      oe_n <= 1'b1;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      ce_n <= !(st_d == S_TRC || st_d == S_TRR);
      oe_n <= !(st_d == S_TRR);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: rdata[7:0] = {ovf_q, 1'b0, tpc_q, tras_q, mode_q, en_q};
      2'd1: rdata[2:0] = cks_q;
      2'd2: rdata = cnt_q;
      default: rdata = cor_q;
    endcase
  end

endmodule

module psram_refresh_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          busy,
  input logic [2:0]    cks_q,
  input logic [CW-1:0] cnt_q,
  input logic          wr_cnt,
  input logic          ovf_q,
  input logic          clr_ovf
);

  // R8
  oe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ce_n);

  // R8
  ce_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n) |-> oe_n);

  // R10
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n) |-> !$past(busy));

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cks_q == 3'd0 && !wr_cnt) |=> $stable(cnt_q));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_ovf) |=> ovf_q);

endmodule

bind psram_refresh_ctl psram_refresh_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
  .cks_q(cks_q), .cnt_q(cnt_q), .wr_cnt(wr_cnt), .ovf_q(ovf_q),
  .clr_ovf(clr_ovf)
);

// File: tb/psram_refresh_ctl_bench.sv
module psram_refresh_ctl_bench;

  logic       clk = 1'b0, rst_n = 1'b0, busy = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ce_n, oe_n;

  int tests = 0, fails = 0, falls = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct { int oe_len; int gap; int ival; string tag; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  psram_refresh_ctl u_psram_refresh_ctl (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ce_n(ce_n), .oe_n(oe_n)
  );

  task automatic chk(input string tag, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic push(input int len, input int gap, input int ival, input string tag);
    exp_t e;
    e.oe_len = len; e.gap = gap; e.ival = ival; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_drain(input int left, input string tag);
    int t = 0;
    while (exp_q.size() > left && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (exp_q.size() > left) chk({tag, " cycles missing"}, exp_q.size(), left);
  endtask

  // monitor: measures each refresh cycle at the pins and compares to the queue
  logic pce = 1'b1, poe = 1'b1;
  int t_cef = 0, t_oef = 0, t_oer = 0, m_gap = 0, m_ival = 0, m_lead = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (pce && !ce_n) begin
        falls++;
        m_gap = cyc - t_oer;
        m_ival = cyc - t_cef;
        t_cef = cyc;
      end
      if (poe && !oe_n) begin
        t_oef = cyc;
        m_lead = cyc - t_cef;
      end
      if (!poe && oe_n) begin
        t_oer = cyc;
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2 unexpected refresh cycle actual=1 expected=0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if ((cyc - t_oef) != e.oe_len || m_lead != 1 || !ce_n ||
              (e.gap != 0 && m_gap != e.gap) || (e.ival != 0 && m_ival != e.ival)) begin
            fails++;
            $display("FAIL %s actual oe=%0d lead=%0d ce_n=%0b gap=%0d ival=%0d expected oe=%0d lead=1 ce_n=1 gap=%0d ival=%0d",
                     e.tag, cyc - t_oef, m_lead, ce_n, m_gap, m_ival, e.oe_len, e.gap, e.ival);
          end
        end
      end
      pce = ce_n;
      poe = oe_n;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v, f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk($sformatf("R1 reg%0d", a), v, 0);
    end
    chk("R1 ce_n", int'(ce_n), 1);
    chk("R1 oe_n", int'(oe_n), 1);

    // R12 readback
    wr(2'd0, 8'h3E); rd(2'd0, v); chk("R12 control", v, 8'h3E);
    wr(2'd3, 8'hA5); rd(2'd3, v); chk("R12 constant", v, 8'hA5);
    wr(2'd1, 8'h07); rd(2'd1, v); chk("R12 select", v, 7);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);

    // R3 stopped counter holds
    wr(2'd3, 8'd200);
    wr(2'd2, 8'd5);
    repeat (50) @(negedge clk);
    rd(2'd2, v); chk("R3 hold", v, 5);

    // R4 resumes from held value: one step in any 4 clocks at /4
    wr(2'd1, 8'd1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rd(2'd2, v); chk("R4 resume", v, 6);

    // R5 dividers
    wr(2'd1, 8'd0); wr(2'd2, 8'd0); wr(2'd1, 8'd2);
    repeat (64) @(posedge clk);
    @(negedge clk);
    rd(2'd2, v); chk("R5 div16", v, 4);
    wr(2'd1, 8'd0); wr(2'd2, 8'd0); wr(2'd1, 8'd5);
    repeat (2048) @(posedge clk);
    @(negedge clk);
    rd(2'd2, v); chk("R5 div1024", v, 2);
    wr(2'd1, 8'd0);

    // R2 gating by mode and enable
    wr(2'd3, 8'd0); wr(2'd2, 8'd0);
    wr(2'd0, 8'h03); wr(2'd1, 8'd1);
    f0 = falls;
    repeat (200) @(negedge clk);
    chk("R2 mode=1", falls - f0, 0);
    wr(2'd0, 8'h00);
    f0 = falls;
    repeat (200) @(negedge clk);
    chk("R2 enable=0", falls - f0, 0);
    wr(2'd1, 8'd0);

    // R6 R7 R8 interval and OE length
    wr(2'd2, 8'd0); wr(2'd3, 8'd3); wr(2'd0, 8'h05);
    push(3, 0, 0, "R7"); push(3, 0, 16, "R6"); push(3, 0, 16, "R6");
    wr(2'd1, 8'd1);
    wait_drain(0, "R6");
    wr(2'd0, 8'h00); wr(2'd1, 8'd0);
    repeat (40) @(negedge clk);

    wr(2'd2, 8'd0); wr(2'd3, 8'd7); wr(2'd0, 8'h1D);
    push(5, 0, 0, "R7"); push(5, 0, 32, "R6"); push(5, 0, 32, "R6");
    wr(2'd1, 8'd1);
    wait_drain(0, "R6");
    wr(2'd0, 8'h00); wr(2'd1, 8'd0);
    repeat (40) @(negedge clk);

    // R9 precharge gap with back-to-back requests, R11 overflow
    wr(2'd2, 8'd0); wr(2'd3, 8'd0); wr(2'd0, 8'h21);
    push(2, 0, 0, "R9"); push(2, 3, 0, "R9"); push(2, 3, 0, "R9"); push(2, 3, 0, "R9");
    wr(2'd1, 8'd1);
    wait_drain(1, "R9");
    wr(2'd0, 8'h20);
    wait_drain(0, "R9");
    repeat (20) @(negedge clk);
    rd(2'd0, v); chk("R11 overflow set", v, 8'hA0);
    wr(2'd0, 8'h20);
    rd(2'd0, v); chk("R11 sticky after plain write", v, 8'hA0);
    wr(2'd0, 8'h80);
    rd(2'd0, v); chk("R11 overflow cleared", v, 8'h00);
    wr(2'd1, 8'd0);

    // R10 busy holds off the start
    busy = 1'b1;
    wr(2'd2, 8'd0); wr(2'd3, 8'd3); wr(2'd0, 8'h01); wr(2'd1, 8'd1);
    f0 = falls;
    repeat (100) @(negedge clk);
    chk("R10 held off", falls - f0, 0);
    wr(2'd0, 8'h00);
    push(2, 0, 0, "R10");
    @(negedge clk);
    busy = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 start on release", int'(ce_n), 0);
    wait_drain(0, "R10");
    repeat (60) @(negedge clk);
    chk("R2 no cycle after disable", exp_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule